// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This unit serves the move-to and move-from special-purpose-register operations of a 32-bit processor core. The core presents a base operand, a 16-bit immediate, write data and the old value of the destination register. The unit combines the operand and the immediate into a register address, splits that address into a group and an index, and then performs the access. It holds the architectural control state: the version, the next and previous program counter, the supervision register, and the exception PC, address and status. It also holds the match and translate arrays of the data and instruction TLBs, the interrupt mask and pending registers, and the tick-timer mode and count registers.

Many of these registers have their own write behaviour. The unit reports that behaviour through one-cycle strobes. A full TLB flush is raised when any translation-relevant supervision bit changes. A per-TLB page flush is raised, together with a page address, when a match entry is invalidated. Timer start and stop strobes are raised when the timer mode changes. Address lookup, the counting engine and exception sequencing are handled by other blocks.

Top module: `spr_unit`

## Requirements
- R1: The register address is `req_base | req_imm`, zero-extended. Bits 31:11 give the group and bits 10:0 give the index. A read returns `rsp_rdata` with `rsp_valid` one clock after it is sampled, and its effects are visible to the next request.
- R2: In group 0, the read/write registers are version at index 0, next PC at 16, previous PC at 18, exception PC at 32, exception address at 48 and exception status at 64. Indices 1 to 4 read the parameters CFG_UPR, CFG_CPU, CFG_DMMU and CFG_IMMU (defaults 0x1, 0x20, 0x18, 0x19), and writes to them are ignored.
- R3: The supervision register is group 0, index 17. Its bit 15 (fixed-one) is stored as 1 after every write, whatever value was written.
- R4: `flush_all` pulses for one cycle after a supervision write only if bit 6 (instruction MMU enable), bit 5 (data MMU enable) or bit 0 (supervisor mode) differs between the old and new value.
- R5: Each TLB has 64 entries. In group 1 (data), match entry i is at index 512+i and translate entry i is at index 640+i. Group 2 (instruction) uses the same layout. Every entry is readable and writable.
- R6: Writing a match entry with bit 0 equal to 0 pulses that TLB's page-flush strobe. The page output is the entry's previous contents with bits 12:0 cleared. Writing with bit 0 equal to 1 gives no pulse.
- R7: In groups 1 and 2, indices 768 to 1535 change no state on a write, and a read of them returns `req_rd_old`.
- R8: The interrupt mask (group 9, index 0) ORs each written value into its contents.
- R9: The interrupt pending register (group 9, index 2) clears every bit that is 1 in the written value. `pic_set` bits set pending bits.
- R10: For the timer mode register (group 10, index 0), bit 28 is the pending bit. A write with bit 28 equal to 1 keeps the stored pending bit. A write with bit 28 equal to 0 clears it. `tmr_fire` sets it, and `tmr_irq` follows it.
- R11: A timer mode write that changes bits 31:30 pulses `tmr_stop` if the new field is 0 and `tmr_start` otherwise. If the field does not change, neither strobe pulses.
- R12: The timer count register (group 10, index 1) stores and returns the written value.
- R13: A read of an unmapped address returns `req_rd_old`, and a write to one changes nothing.
- R14: After reset, every register reads 0 except the supervision register, which reads 0x8001, and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = move-to, 0 = move-from |
| req_base | input | 32 | Base operand |
| req_imm | input | 16 | Immediate, ORed into the base |
| req_wdata | input | 32 | Write data |
| req_rd_old | input | 32 | Current destination value, returned for unmapped reads |
| pic_set | input | 32 | Interrupt lines setting pending bits |
| tmr_fire | input | 1 | Timer match event, sets pending |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| flush_all | output | 1 | Full TLB flush strobe |
| dtlb_pflush | output | 1 | Data TLB page flush strobe |
| dtlb_page | output | 32 | Page address for the data flush |
| itlb_pflush | output | 1 | Instruction TLB page flush strobe |
| itlb_page | output | 32 | Page address for the instruction flush |
| tmr_start | output | 1 | Timer start strobe |
| tmr_stop | output | 1 | Timer stop strobe |
| tmr_irq | output | 1 | Timer interrupt request |

## Verification
Some properties are checked on every cycle: the fixed-one bit, the link between `flush_all` and actual changes in the supervision bits, the mask never losing bits, the exclusive and causal timer strobes, the pending bit's keep and clear rules, and page flushes occurring only after invalidating match writes. Other behaviours are shown only by the scenarios: address formation by OR, decoding of each index, the page address taken from old contents, the silence of the ignored ranges, the fallback for unmapped reads, and the reset values. In those scenarios, read data is compared through a queue of expected values.

// File: rtl/spr_pkg.sv
package spr_pkg;
  typedef enum logic [4:0] {
    SEL_NONE, SEL_VR, SEL_UPR, SEL_CPUCFG, SEL_DMMUCFG, SEL_IMMUCFG,
    SEL_NPC, SEL_SR, SEL_PPC, SEL_EPCR, SEL_EEAR, SEL_ESR,
    SEL_DTLB_M, SEL_DTLB_T, SEL_ITLB_M, SEL_ITLB_T,
    SEL_PICM, SEL_PICS, SEL_TMODE, SEL_TCNT
  } spr_sel_e;

  localparam int SR_SM  = 0;
  localparam int SR_DME = 5;
  localparam int SR_IME = 6;
  localparam int SR_FO  = 15;
  localparam int TM_IP  = 28;
  localparam int TM_MLO = 30;
  localparam int TM_MHI = 31;
endpackage

// File: rtl/spr_decode.sv
module spr_decode
  import spr_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int TLB_ENTRIES = 64,
  localparam int IDXW       = $clog2(TLB_ENTRIES)
) (
  input  logic [XLEN-1:0] base,
  input  logic [15:0]     imm,
  output spr_sel_e        sel,
  output logic [IDXW-1:0] idx
);
  localparam int GW = XLEN - 11;
  localparam logic [10:0] M_LO = 11'd512;
  localparam logic [10:0] M_HI = 11'(512 + TLB_ENTRIES);
  localparam logic [10:0] T_LO = 11'd640;
  localparam logic [10:0] T_HI = 11'(640 + TLB_ENTRIES);

  logic [XLEN-1:0] addr;
  logic [GW-1:0]   grp;
  logic [10:0]     num;
  spr_sel_e        tlb_m, tlb_t;

  assign addr = base | {{(XLEN-16){1'b0}}, imm};
  assign grp  = addr[XLEN-1:11];
  assign num  = addr[10:0];
  // Bases 512 and 640 are multiples of 128, so the low bits are the entry index.
  assign idx  = num[IDXW-1:0];

  always_comb begin
    tlb_m = (grp == GW'(1)) ? SEL_DTLB_M : SEL_ITLB_M;
    tlb_t = (grp == GW'(1)) ? SEL_DTLB_T : SEL_ITLB_T;
    sel   = SEL_NONE;
    if (grp == '0) begin
      case (num)
        11'd0:  sel = SEL_VR;
        11'd1:  sel = SEL_UPR;
        11'd2:  sel = SEL_CPUCFG;
        11'd3:  sel = SEL_DMMUCFG;
        11'd4:  sel = SEL_IMMUCFG;
        11'd16: sel = SEL_NPC;
        11'd17: sel = SEL_SR;
        11'd18: sel = SEL_PPC;
        11'd32: sel = SEL_EPCR;
        11'd48: sel = SEL_EEAR;
        11'd64: sel = SEL_ESR;
        default: sel = SEL_NONE;
      endcase
    end else if (grp == GW'(1) || grp == GW'(2)) begin
      if (num >= M_LO && num < M_HI)      sel = tlb_m;
      else if (num >= T_LO && num < T_HI) sel = tlb_t;
      else                                sel = SEL_NONE;
    end else if (grp == GW'(9)) begin
      if (num == 11'd0)      sel = SEL_PICM;
      else if (num == 11'd2) sel = SEL_PICS;
    end else if (grp == GW'(10)) begin
      if (num == 11'd0)      sel = SEL_TMODE;
      else if (num == 11'd1) sel = SEL_TCNT;
    end
  end
endmodule

// File: rtl/spr_tlb_bank.sv
module spr_tlb_bank #(
  parameter int XLEN      = 32,
  parameter int ENTRIES   = 64,
  parameter int PAGE_BITS = 13,
  localparam int IDXW     = $clog2(ENTRIES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_m,
  input  logic            wr_t,
  input  logic [IDXW-1:0] idx,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] rd_m,
  output logic [XLEN-1:0] rd_t,
  output logic            pflush,
  output logic [XLEN-1:0] paddr
);
  localparam logic [XLEN-1:0] PMASK = ~((XLEN'(1) << PAGE_BITS) - XLEN'(1));

  logic [XLEN-1:0] m_q [ENTRIES];
  logic [XLEN-1:0] t_q [ENTRIES];
  logic            pflush_d;
  logic [XLEN-1:0] paddr_d;

  assign rd_m = m_q[idx];
  assign rd_t = t_q[idx];

  always_comb begin
    pflush_d = wr_m & ~wdata[0];
    paddr_d  = pflush_d ? (m_q[idx] & PMASK) : paddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        m_q[i] <= '0;
        t_q[i] <= '0;
      end
      pflush <= 1'b0;
      paddr  <= '0;
    end else begin
      if (wr_m) m_q[idx] <= wdata;
      if (wr_t) t_q[idx] <= wdata;
      pflush <= pflush_d;
      paddr  <= paddr_d;
    end
  end

  assert_pflush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pflush |-> ($past(wr_m) && !$past(wdata[0])));
  assert_page_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pflush |-> ((paddr & ~PMASK) == '0));
endmodule

// File: rtl/spr_tick.sv
module spr_tick
  import spr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mode,
  input  logic            wr_cnt,
  input  logic [XLEN-1:0] wdata,
  input  logic            fire,
  output logic [XLEN-1:0] mode_q,
  output logic [XLEN-1:0] cnt_q,
  output logic            start,
  output logic            stop,
  output logic            irq
);
  logic [XLEN-1:0] mode_d, cnt_d;
  logic            chg, start_d, stop_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = wr_cnt ? wdata : cnt_q;
    chg    = wr_mode && (wdata[TM_MHI:TM_MLO] != mode_q[TM_MHI:TM_MLO]);
    if (wr_mode) begin
      mode_d        = wdata;
      mode_d[TM_IP] = wdata[TM_IP] & mode_q[TM_IP];
    end
    if (fire) mode_d[TM_IP] = 1'b1;
    start_d = chg && (wdata[TM_MHI:TM_MLO] != 2'b00);
    stop_d  = chg && (wdata[TM_MHI:TM_MLO] == 2'b00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
      start  <= 1'b0;
      stop   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      start  <= start_d;
      stop   <= stop_d;
    end
  end

  assign irq = mode_q[TM_IP];

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && stop));
  assert_strobe_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start || stop) |-> (mode_q[TM_MHI:TM_MLO] != $past(mode_q[TM_MHI:TM_MLO])));
  assert_pend_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wdata[TM_IP] && !fire) |=> (irq == $past(irq)));
  assert_pend_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && !wdata[TM_IP] && !fire) |=> !irq);
endmodule

// File: rtl/spr_unit.sv
module spr_unit
  import spr_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter int              TLB_ENTRIES = 64,
  parameter int              PAGE_BITS   = 13,
  parameter logic [XLEN-1:0] CFG_UPR     = 32'h0000_0001,
  parameter logic [XLEN-1:0] CFG_CPU     = 32'h0000_0020,
  parameter logic [XLEN-1:0] CFG_DMMU    = 32'h0000_0018,
  parameter logic [XLEN-1:0] CFG_IMMU    = 32'h0000_0019
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [XLEN-1:0] req_base,
  input  logic [15:0]     req_imm,
  input  logic [XLEN-1:0] req_wdata,
  input  logic [XLEN-1:0] req_rd_old,
  input  logic [XLEN-1:0] pic_set,
  input  logic            tmr_fire,
  output logic            rsp_valid,
  output logic [XLEN-1:0] rsp_rdata,
  output logic            flush_all,
  output logic            dtlb_pflush,
  output logic [XLEN-1:0] dtlb_page,
  output logic            itlb_pflush,
  output logic [XLEN-1:0] itlb_page,
  output logic            tmr_start,
  output logic            tmr_stop,
  output logic            tmr_irq
);
  localparam int IDXW = $clog2(TLB_ENTRIES);
  localparam logic [XLEN-1:0] SR_RST  = XLEN'((1 << SR_FO) | (1 << SR_SM));
  localparam logic [XLEN-1:0] SR_XLAT = XLEN'((1 << SR_IME) | (1 << SR_DME) | (1 << SR_SM));

  spr_sel_e        sel;
  logic [IDXW-1:0] idx;
  logic            wr, rd;
  logic [XLEN-1:0] vr_q, npc_q, sr_q, ppc_q, epcr_q, eear_q, esr_q, picm_q, pics_q;
  logic [XLEN-1:0] vr_d, npc_d, sr_d, ppc_d, epcr_d, eear_d, esr_d, picm_d, pics_d;
  logic [XLEN-1:0] rd_mux, rdata_d, tmode, tcnt;
  logic            flush_d;
  logic [XLEN-1:0] tlb_m [2];
  logic [XLEN-1:0] tlb_t [2];
  logic [1:0]      tlb_pf;
  logic [XLEN-1:0] tlb_pa [2];

  assign wr = req_valid & req_write;
  assign rd = req_valid & ~req_write;

  spr_decode #(.XLEN(XLEN), .TLB_ENTRIES(TLB_ENTRIES)) i_dec (
    .base(req_base), .imm(req_imm), .sel(sel), .idx(idx));

  for (genvar g = 0; g < 2; g++) begin : g_tlb
    localparam spr_sel_e SM = (g == 0) ? SEL_DTLB_M : SEL_ITLB_M;
    localparam spr_sel_e ST = (g == 0) ? SEL_DTLB_T : SEL_ITLB_T;
    spr_tlb_bank #(.XLEN(XLEN), .ENTRIES(TLB_ENTRIES), .PAGE_BITS(PAGE_BITS)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_m(wr && sel == SM), .wr_t(wr && sel == ST),
      .idx(idx), .wdata(req_wdata),
      .rd_m(tlb_m[g]), .rd_t(tlb_t[g]),
      .pflush(tlb_pf[g]), .paddr(tlb_pa[g]));
  end

  assign dtlb_pflush = tlb_pf[0];
  assign dtlb_page   = tlb_pa[0];
  assign itlb_pflush = tlb_pf[1];
  assign itlb_page   = tlb_pa[1];

  spr_tick #(.XLEN(XLEN)) i_tick (
    .clk(clk), .rst_n(rst_n),
    .wr_mode(wr && sel == SEL_TMODE), .wr_cnt(wr && sel == SEL_TCNT),
    .wdata(req_wdata), .fire(tmr_fire),
    .mode_q(tmode), .cnt_q(tcnt),
    .start(tmr_start), .stop(tmr_stop), .irq(tmr_irq));

  always_comb begin
    vr_d = vr_q; npc_d = npc_q; sr_d = sr_q; ppc_d = ppc_q;
    epcr_d = epcr_q; eear_d = eear_q; esr_d = esr_q;
    picm_d = picm_q; pics_d = pics_q;
    flush_d = 1'b0;
    if (wr) begin
      case (sel)
        SEL_VR:   vr_d   = req_wdata;
        SEL_NPC:  npc_d  = req_wdata;
        SEL_PPC:  ppc_d  = req_wdata;
        SEL_EPCR: epcr_d = req_wdata;
        SEL_EEAR: eear_d = req_wdata;
        SEL_ESR:  esr_d  = req_wdata;
        SEL_SR: begin
          sr_d        = req_wdata;
          sr_d[SR_FO] = 1'b1;
          flush_d     = ((sr_q ^ req_wdata) & SR_XLAT) != '0;
        end
        SEL_PICM: picm_d = picm_q | req_wdata;
        SEL_PICS: pics_d = pics_q & ~req_wdata;
        default: ;
      endcase
    end
    pics_d = pics_d | pic_set;
  end

  always_comb begin
    case (sel)
      SEL_VR:      rd_mux = vr_q;
      SEL_UPR:     rd_mux = CFG_UPR;
      SEL_CPUCFG:  rd_mux = CFG_CPU;
      SEL_DMMUCFG: rd_mux = CFG_DMMU;
      SEL_IMMUCFG: rd_mux = CFG_IMMU;
      SEL_NPC:     rd_mux = npc_q;
      SEL_SR:      rd_mux = sr_q;
      SEL_PPC:     rd_mux = ppc_q;
      SEL_EPCR:    rd_mux = epcr_q;
      SEL_EEAR:    rd_mux = eear_q;
      SEL_ESR:     rd_mux = esr_q;
      SEL_DTLB_M:  rd_mux = tlb_m[0];
      SEL_DTLB_T:  rd_mux = tlb_t[0];
      SEL_ITLB_M:  rd_mux = tlb_m[1];
      SEL_ITLB_T:  rd_mux = tlb_t[1];
      SEL_PICM:    rd_mux = picm_q;
      SEL_PICS:    rd_mux = pics_q;
      SEL_TMODE:   rd_mux = tmode;
      SEL_TCNT:    rd_mux = tcnt;
      default:     rd_mux = req_rd_old;
    endcase
    rdata_d = rd ? rd_mux : rsp_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vr_q <= '0; npc_q <= '0; sr_q <= SR_RST; ppc_q <= '0;
      epcr_q <= '0; eear_q <= '0; esr_q <= '0; picm_q <= '0; pics_q <= '0;
      flush_all <= 1'b0; rsp_valid <= 1'b0; rsp_rdata <= '0;
    end else begin
      vr_q <= vr_d; npc_q <= npc_d; sr_q <= sr_d; ppc_q <= ppc_d;
      epcr_q <= epcr_d; eear_q <= eear_d; esr_q <= esr_d;
      picm_q <= picm_d; pics_q <= pics_d;
      flush_all <= flush_d; rsp_valid <= rd; rsp_rdata <= rdata_d;
    end
  end

  assert_fo_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[SR_FO]);
  assert_flush_only_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> (((sr_q ^ $past(sr_q)) & SR_XLAT) != '0));
  assert_flush_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((sr_q ^ $past(sr_q)) & SR_XLAT) != '0) |-> flush_all);
  assert_mask_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(picm_q) & ~picm_q) == '0));
endmodule

// File: tb/test_spr_unit.sv
`timescale 1ns/1ps
module test_spr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, tmr_fire = 1'b0;
  logic [31:0] req_base = '0, req_wdata = '0, req_rd_old = '0, pic_set = '0;
  logic [15:0] req_imm = '0;
  logic        rsp_valid, flush_all, dtlb_pflush, itlb_pflush, tmr_start, tmr_stop, tmr_irq;
  logic [31:0] rsp_rdata, dtlb_page, itlb_page;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  spr_unit i_spr_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata), .req_rd_old(req_rd_old),
    .pic_set(pic_set), .tmr_fire(tmr_fire), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .flush_all(flush_all), .dtlb_pflush(dtlb_pflush), .dtlb_page(dtlb_page),
    .itlb_pflush(itlb_pflush), .itlb_page(itlb_page),
    .tmr_start(tmr_start), .tmr_stop(tmr_stop), .tmr_irq(tmr_irq));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] base, input logic [15:0] imm, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_base = base; req_imm = imm; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [31:0] base, input logic [15:0] imm,
                    input logic [31:0] old, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_base = base; req_imm = imm; req_rd_old = old;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each returned read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(1, 0, "R1 unexpected response");
      else chk(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic strobes(input logic [5:0] exp, input string tag);
    chk({26'd0, flush_all, dtlb_pflush, itlb_pflush, tmr_start, tmr_stop, tmr_irq},
        {26'd0, exp}, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R14 reset state
    @(negedge clk);
    strobes(6'b000000, "R14 strobes after reset");
    rd(0, 16'd17, 0, 32'h0000_8001, "R14 SR reset");
    rd(0, 16'd16, 0, 32'h0, "R14 NPC reset");
    rd(0, 16'h4800, 0, 32'h0, "R14 mask reset");
    rd(0, 16'h0A03, 0, 32'h0, "R14 DTLB reset");
    // R1 address by OR
    rd(32'h0000_0010, 16'h0001, 0, 32'h0000_8001, "R1 OR address to SR");
    rd(32'h0001_0000, 16'h0010, 32'h1111, 32'h1111, "R1 high group bits unmapped");
    // R2 group 0
    wr(0, 16'd0, 32'hA5A5_0001); rd(0, 16'd0, 0, 32'hA5A5_0001, "R2 VR");
    wr(0, 16'd16, 32'h0000_1000); rd(0, 16'd16, 0, 32'h0000_1000, "R2 NPC");
    wr(0, 16'd18, 32'h0000_0FFC); rd(0, 16'd18, 0, 32'h0000_0FFC, "R2 PPC");
    wr(0, 16'd32, 32'hCAFE_0000); rd(0, 16'd32, 0, 32'hCAFE_0000, "R2 EPC");
    wr(0, 16'd48, 32'hBEEF_0004); rd(0, 16'd48, 0, 32'hBEEF_0004, "R2 EEA");
    wr(0, 16'd64, 32'h0000_0077); rd(0, 16'd64, 0, 32'h0000_0077, "R2 ESR");
    wr(0, 16'd1, 32'hFFFF_FFFF); rd(0, 16'd1, 0, 32'h1, "R2 UPR read-only");
    rd(0, 16'd2, 0, 32'h20, "R2 CPU cfg"); rd(0, 16'd3, 0, 32'h18, "R2 DMMU cfg");
    rd(0, 16'd4, 0, 32'h19, "R2 IMMU cfg");
    // R3/R4 supervision register
    wr(0, 16'd17, 32'h0000_0060); strobes(6'b100000, "R4 flush on change");
    rd(0, 16'd17, 0, 32'h0000_8060, "R3 FO forced");
    wr(0, 16'd17, 32'h0000_8060); strobes(6'b000000, "R4 no flush when same");
    wr(0, 16'd17, 32'h0000_0F00); strobes(6'b100000, "R4 flush on clear");
    rd(0, 16'd17, 0, 32'h0000_8F00, "R3 FO forced again");
    wr(0, 16'd17, 32'h0000_0E00); strobes(6'b000000, "R4 other bits no flush");
    // R5/R6 TLBs
    wr(0, 16'h0A03, 32'h1234_5679); strobes(6'b000000, "R6 valid write no flush");
    wr(0, 16'h0A83, 32'hABCD_0000);
    rd(0, 16'h0A03, 0, 32'h1234_5679, "R5 DTLB match");
    rd(0, 16'h0A83, 0, 32'hABCD_0000, "R5 DTLB translate");
    wr(0, 16'h0A03, 32'h0000_0000); strobes(6'b010000, "R6 DTLB page flush");
    chk(dtlb_page, 32'h1234_4000, "R6 DTLB page from old");
    rd(0, 16'h0A03, 0, 32'h0, "R5 DTLB match cleared");
    wr(32'h0000_1000, 16'h023F, 32'h8000_2001);
    wr(32'h0000_1000, 16'h02BF, 32'h0000_5555);
    rd(0, 16'h123F, 0, 32'h8000_2001, "R5 ITLB last match");
    rd(0, 16'h12BF, 0, 32'h0000_5555, "R5 ITLB last translate");
    wr(0, 16'h123F, 32'h0000_0002); strobes(6'b001000, "R6 ITLB page flush");
    chk(itlb_page, 32'h8000_2000, "R6 ITLB page from old");
    // R7 ignored range
    wr(0, 16'h0B00, 32'hFFFF_FFFF); strobes(6'b000000, "R7 ignored write");
    rd(0, 16'h0B00, 32'h55, 32'h55, "R7 ignored read");
    rd(0, 16'h15FF, 32'h66, 32'h66, "R7 ignored read top");
    rd(0, 16'h0A83, 0, 32'hABCD_0000, "R7 neighbours intact");
    // R8/R9 interrupt controller
    wr(0, 16'h4800, 32'h0F); wr(0, 16'h4800, 32'hF0); wr(0, 16'h4800, 32'h0);
    rd(0, 16'h4800, 0, 32'hFF, "R8 mask OR");
    @(negedge clk); pic_set = 32'hFF00; @(negedge clk); pic_set = '0;
    rd(0, 16'h4802, 0, 32'hFF00, "R9 pending set");
    wr(0, 16'h4802, 32'h0F00); rd(0, 16'h4802, 0, 32'hF000, "R9 clear on write");
    // R10/R11/R12 tick timer
    wr(0, 16'h5000, 32'h4000_0000); strobes(6'b000100, "R11 start on mode 1");
    @(negedge clk); tmr_fire = 1'b1; @(negedge clk); tmr_fire = 1'b0;
    strobes(6'b000001, "R10 fire raises irq");
    wr(0, 16'h5000, 32'h9000_0000); strobes(6'b000101, "R10 R11 keep pending, start");
    rd(0, 16'h5000, 0, 32'h9000_0000, "R10 mode readback");
    wr(0, 16'h5000, 32'h0000_0000); strobes(6'b000010, "R11 stop, R10 clear irq");
    wr(0, 16'h5000, 32'h0000_00FF); strobes(6'b000000, "R11 no strobe unchanged");
    wr(0, 16'h5000, 32'h1000_0001);
    rd(0, 16'h5000, 0, 32'h0000_0001, "R10 pending not set by write");
    wr(0, 16'h5001, 32'h0000_1234); rd(0, 16'h5001, 0, 32'h0000_1234, "R12 count");
    // R13 unmapped
    wr(0, 16'h7800, 32'hFFFF_FFFF); strobes(6'b000000, "R13 unmapped write");
    rd(0, 16'h7800, 32'hDEAD, 32'hDEAD, "R13 unmapped read");
    rd(0, 16'd5, 32'h77, 32'h77, "R13 gap in group 0");
    @(negedge clk); @(negedge clk);
    chk(exp_q.size(), 0, "R1 all responses seen");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule